// File: doc/BRIEF.md
# Delay-Aligned Stream Window Adder

This block sums several time-shifted copies of one input stream. Each tap is given a shift N and presents the stream N valid samples ahead of the base sample. The taps line up through delays that differ per tap, so every input of the final adder carries a sample of the same window in the same cycle. A tap may also be routed through an extra pipeline register. When any tap uses one, the other taps are delayed by one more cycle so that the alignment holds.

A run begins with a one-cycle `run` pulse while the `running` level is high. The run captures the tap shifts, the pipeline flags and a source delay, which is the number of cycles after the run cycle before the first real sample appears on `src_data`. Anything on the input before that point is garbage and never reaches a valid output. A counter measures the time since the run. Once the longest path has filled, the registered adder produces one wrapped window sum per cycle, qualified by `out_valid`.

Top module: `stream_window_adder`

## Requirements
- R1: During and right after reset, `out_valid` is 0 and `sum_out` is 0.
- R2: In the k-th valid output cycle of a run (k from 0), `sum_out` equals the sum over taps of source sample k+N, where N is that tap's shift. Source sample i is the value on `src_data` in the cycle src_delay+i after the run cycle. Tap t's shift is `tap_shift[t*SHIFT_W +: SHIFT_W]`.
- R3: With shifts 0,1,2,3, no pipeline flags, a source delay of 0 and a source counting up from 0, the first four valid sums are 6, 10, 14 and 18.
- R4: Setting bit t of `tap_pipe` puts tap t through one extra register. The sums are the same as without the flag, and the first valid output comes one cycle later.
- R5: Values on `src_data` before cycle src_delay of a run have no effect on any valid output.
- R6: Call the run cycle 0. `out_valid` first rises in cycle src_delay + Smax + P + 1, where Smax is the largest captured shift and P is 1 if any pipeline flag is set and 0 otherwise.
- R7: Whenever `out_valid` is 0, `sum_out` is 0.
- R8: A cycle with `running` low makes `out_valid` 0 in the next cycle. A later run again waits the full latency of R6.
- R9: The sum wraps modulo 2^DATA_W.
- R10: Shifts, pipeline flags and source delay are taken only in a run cycle. Changing them during a run does not alter that run's outputs.
- R11: Once `out_valid` is 1, it stays 1 in every following cycle while `running` stays high and no new `run` arrives.
- R12: A `run` pulse during an active run restarts it. The new configuration is captured, the sample numbering starts again, and the R6 latency applies from the new run cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | One-cycle start pulse, taken only while `running` is high |
| running | input | 1 | High for the whole duration of a run |
| src_data | input | DATA_W | Source stream sample |
| tap_shift | input | NTAPS*SHIFT_W | Per-tap shift in samples, tap t at bits t*SHIFT_W upward |
| tap_pipe | input | NTAPS | Per-tap extra pipeline register flag |
| src_delay | input | DELAY_W | Cycles after the run cycle before the first real sample |
| sum_out | output | DATA_W | Registered window sum, 0 when not valid |
| out_valid | output | 1 | Sum qualifier |

## Verification
Two things can land on the same clock edge: a fresh `run` pulse, which recaptures the configuration and restarts the elapsed count, and a valid window sum from the previous run. The bench provokes this by issuing a second run while the first one is already producing valid sums. It also changes the configuration inputs in the middle of a run without a pulse. A behavioural queue model predicts every cycle's output from the captured configuration. Any mixing of the old and new configuration, or a valid flag that fails to drop for the restarted latency, shows up as a mismatch.

// File: rtl/swa_pkg.sv
package swa_pkg;

  // Cycles a tap must be held back so that it meets the slowest tap.
  function automatic int unsigned tap_gap(input int unsigned smax, input int unsigned shift,
                                          input bit pany, input bit pipe);
    int unsigned g;
    g = smax - shift;
    if (pany && !pipe) g = g + 1;
    return g;
  endfunction

  // Elapsed cycles after which a tap carries a real sample.
  function automatic int unsigned live_threshold(input int unsigned delay, input int unsigned smax,
                                                 input bit pany, input int unsigned shift);
    return delay + smax + (pany ? 1 : 0) - shift;
  endfunction

  // Elapsed cycles after which every tap carries a real sample.
  function automatic int unsigned fill_threshold(input int unsigned delay, input int unsigned smax,
                                                 input bit pany);
    return delay + smax + (pany ? 1 : 0);
  endfunction

endpackage

// File: rtl/swa_history.sv
module swa_history #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DATA_W-1:0]            din,
  output logic [DEPTH-1:0][DATA_W-1:0] hist
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
    end else begin
      hist[0] <= din;
      for (int j = 1; j < DEPTH; j++) begin
        hist[j] <= hist[j-1];
      end
    end
  end

endmodule

// File: rtl/swa_tap.sv
module swa_tap #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int SEL_W  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DATA_W-1:0]            din,
  input  logic [DEPTH-1:0][DATA_W-1:0] hist,
  input  logic [SEL_W-1:0]             gap,
  input  logic                         use_pipe,
  output logic [DATA_W-1:0]            tap_val
);

  logic [DATA_W-1:0] picked;
  logic [DATA_W-1:0] pipe_q;

  // gap 0 is the live input, gap g is the sample taken g edges ago
  always_comb begin
    picked = din;
    for (int j = 0; j < DEPTH; j++) begin
      if (gap == SEL_W'(j + 1)) picked = hist[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= picked;
  end

  assign tap_val = use_pipe ? pipe_q : picked;

endmodule

// File: rtl/swa_align_ctl.sv
module swa_align_ctl #(
  parameter int NTAPS   = 4,
  parameter int SHIFT_W = 3,
  parameter int DELAY_W = 6,
  parameter int SEL_W   = 4,
  parameter int CNT_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     running,
  input  logic [NTAPS*SHIFT_W-1:0] shift_in,
  input  logic [NTAPS-1:0]         pipe_in,
  input  logic [DELAY_W-1:0]       delay_in,
  output logic [NTAPS*SEL_W-1:0]   gap_flat,
  output logic [NTAPS-1:0]         pipe_sel,
  output logic [NTAPS-1:0]         tap_live,
  output logic                     all_live
);
  import swa_pkg::*;

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [NTAPS*SHIFT_W-1:0] shift_q, shift_now;
  logic [NTAPS-1:0]         pipe_q, pipe_now;
  logic [DELAY_W-1:0]       delay_q, delay_now;
  logic [CNT_W-1:0]         cnt_q;
  logic [CNT_W-1:0]         elapsed;
  logic [CNT_W-1:0]         fill_thr;
  logic [SHIFT_W-1:0]       smax;
  logic                     pany;
  logic                     start;
  logic                     armed;

  assign start = run & running;

  // configuration shadow: the run cycle sees the new values directly
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      pipe_q  <= '0;
      delay_q <= '0;
    end else if (start) begin
      shift_q <= shift_in;
      pipe_q  <= pipe_in;
      delay_q <= delay_in;
    end
  end

  assign shift_now = start ? shift_in : shift_q;
  assign pipe_now  = start ? pipe_in  : pipe_q;
  assign delay_now = start ? delay_in : delay_q;

  // cnt_q holds elapsed+1 of the current cycle; zero means no run is armed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!running) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= CNT_W'(2);
    end else if (cnt_q != '0 && cnt_q != CNT_TOP) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign armed   = start | (cnt_q != '0);
  assign elapsed = start ? '0 : (cnt_q - CNT_W'(1));

  always_comb begin
    smax = '0;
    for (int t = 0; t < NTAPS; t++) begin
      if (shift_now[t*SHIFT_W +: SHIFT_W] > smax) smax = shift_now[t*SHIFT_W +: SHIFT_W];
    end
  end

  assign pany     = |pipe_now;
  assign fill_thr = CNT_W'(fill_threshold(32'(delay_now), 32'(smax), pany));
  assign all_live = armed & running & (elapsed >= fill_thr);
  assign pipe_sel = pipe_now;

  for (genvar t = 0; t < NTAPS; t++) begin : g_tapcfg
    logic [SHIFT_W-1:0] sh;
    logic [CNT_W-1:0]   thr;
    assign sh  = shift_now[t*SHIFT_W +: SHIFT_W];
    assign gap_flat[t*SEL_W +: SEL_W] = SEL_W'(tap_gap(32'(smax), 32'(sh), pany, pipe_now[t]));
    assign thr = CNT_W'(live_threshold(32'(delay_now), 32'(smax), pany, 32'(sh)));
    assign tap_live[t] = armed & running & (elapsed >= thr);
  end

endmodule

// File: rtl/swa_sum.sv
module swa_sum #(
  parameter int NTAPS  = 4,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NTAPS*DATA_W-1:0] tap_flat,
  input  logic [NTAPS-1:0]        tap_live,
  input  logic                    load,
  output logic [DATA_W-1:0]       sum_q,
  output logic                    vld_q
);

  // wrapped sum of the taps that already carry real samples
  function automatic logic [DATA_W-1:0] window_total(input logic [NTAPS*DATA_W-1:0] v,
                                                     input logic [NTAPS-1:0] live);
    logic [DATA_W-1:0] acc;
    acc = '0;
    for (int t = 0; t < NTAPS; t++) begin
      if (live[t]) acc = acc + v[t*DATA_W +: DATA_W];
    end
    return acc;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= load;
      sum_q <= load ? window_total(tap_flat, tap_live) : '0;
    end
  end

endmodule

// File: rtl/stream_window_adder.sv
module stream_window_adder #(
  parameter int DATA_W  = 16,
  parameter int NTAPS   = 4,
  parameter int SHIFT_W = 3,
  parameter int DELAY_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     running,
  input  logic [DATA_W-1:0]        src_data,
  input  logic [NTAPS*SHIFT_W-1:0] tap_shift,
  input  logic [NTAPS-1:0]         tap_pipe,
  input  logic [DELAY_W-1:0]       src_delay,
  output logic [DATA_W-1:0]        sum_out,
  output logic                     out_valid
);

  localparam int DEPTH = 2 ** SHIFT_W;
  localparam int SEL_W = SHIFT_W + 1;
  localparam int CNT_W = ((DELAY_W > SHIFT_W) ? DELAY_W : SHIFT_W) + 2;

  logic [DEPTH-1:0][DATA_W-1:0] hist;
  logic [NTAPS*SEL_W-1:0]       gap_flat;
  logic [NTAPS-1:0]             pipe_sel;
  logic [NTAPS-1:0]             tap_live;
  logic                         all_live;
  logic [NTAPS*DATA_W-1:0]      tap_flat;

  swa_align_ctl #(
    .NTAPS(NTAPS), .SHIFT_W(SHIFT_W), .DELAY_W(DELAY_W), .SEL_W(SEL_W), .CNT_W(CNT_W)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .run(run), .running(running),
    .shift_in(tap_shift), .pipe_in(tap_pipe), .delay_in(src_delay),
    .gap_flat(gap_flat), .pipe_sel(pipe_sel), .tap_live(tap_live), .all_live(all_live)
  );

  swa_history #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_hist (
    .clk(clk), .rst_n(rst_n), .din(src_data), .hist(hist)
  );

  for (genvar t = 0; t < NTAPS; t++) begin : g_tap
    swa_tap #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SEL_W(SEL_W)) u_tap (
      .clk(clk), .rst_n(rst_n), .din(src_data), .hist(hist),
      .gap(gap_flat[t*SEL_W +: SEL_W]), .use_pipe(pipe_sel[t]),
      .tap_val(tap_flat[t*DATA_W +: DATA_W])
    );
  end

  swa_sum #(.NTAPS(NTAPS), .DATA_W(DATA_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .tap_flat(tap_flat), .tap_live(tap_live),
    .load(all_live), .sum_q(sum_out), .vld_q(out_valid)
  );

endmodule

// File: rtl/swa_checker.sv
module swa_checker #(
  parameter int NTAPS  = 4,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              running,
  input logic [DATA_W-1:0] sum_out,
  input logic              out_valid,
  input logic [NTAPS-1:0]  tap_live,
  input logic              all_live
);

  p_idle_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !out_valid);

  p_zero_when_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (sum_out == '0));

  p_valid_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && running && !run) |=> out_valid);

  p_fill_covers_taps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    all_live |-> (tap_live == '1));

  p_fill_gives_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    all_live |=> out_valid);

  p_valid_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(all_live));

endmodule

bind stream_window_adder swa_checker #(.NTAPS(NTAPS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .running(running),
  .sum_out(sum_out), .out_valid(out_valid), .tap_live(tap_live), .all_live(all_live)
);

// File: tb/sim_stream_window_adder.sv
`timescale 1ns/1ps
module sim_stream_window_adder;

  localparam int DW = 16;
  localparam int NT = 4;
  localparam int SW = 3;
  localparam int DLW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run = 1'b0;
  logic          running = 1'b0;
  logic [DW-1:0] src_data = '0;
  logic [NT*SW-1:0] tap_shift = '0;
  logic [NT-1:0] tap_pipe = '0;
  logic [DLW-1:0] src_delay = '0;
  logic [DW-1:0] sum_out;
  logic          out_valid;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  logic [DW-1:0] q[$];
  bit  act = 0;
  int  cc = 0;
  int  m_shift[NT];
  bit  m_pipe[NT];
  int  m_sd = 0;

  // observation of the DUT per run
  int  first_seen = -1;
  int  dn = 0;
  logic [DW-1:0] dsum[8];

  always #2.5 clk = ~clk;

  stream_window_adder #(.DATA_W(DW), .NTAPS(NT), .SHIFT_W(SW), .DELAY_W(DLW)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .running(running), .src_data(src_data),
    .tap_shift(tap_shift), .tap_pipe(tap_pipe), .src_delay(src_delay),
    .sum_out(sum_out), .out_valid(out_valid)
  );

  task automatic check(input string tag, input logic [DW-1:0] act_v, input logic [DW-1:0] exp_v);
    n_tests++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act_v, exp_v);
    end
  endtask

  // one cycle: compare the outputs of this cycle, then drive its inputs
  task automatic tick(input bit r, input bit rn, input logic [DW-1:0] d, input string tag);
    int smax;
    int lat;
    int k;
    bit pany;
    bit exp_v;
    logic [DW-1:0] exp_s;
    @(negedge clk);
    smax = 0;
    pany = 0;
    for (int t = 0; t < NT; t++) begin
      if (m_shift[t] > smax) smax = m_shift[t];
      if (m_pipe[t]) pany = 1;
    end
    lat = m_sd + smax + (pany ? 1 : 0) + 1;
    exp_v = act && (cc >= lat);
    exp_s = '0;
    if (exp_v) begin
      k = cc - lat;
      for (int t = 0; t < NT; t++) exp_s = exp_s + q[k + m_shift[t]];
    end
    n_tests++;
    if (out_valid !== exp_v || sum_out !== exp_s) begin
      n_fail++;
      $display("FAIL %s: valid=%0b sum=%0d expected valid=%0b sum=%0d",
               tag, out_valid, sum_out, exp_v, exp_s);
    end
    if (out_valid === 1'b1) begin
      if (first_seen < 0) first_seen = cc;
      if (dn < 8) begin
        dsum[dn] = sum_out;
        dn++;
      end
    end
    run = r;
    running = rn;
    src_data = d;
    if (r && rn) begin
      act = 1;
      cc = 0;
      q.delete();
      for (int t = 0; t < NT; t++) begin
        m_shift[t] = int'(tap_shift[t*SW +: SW]);
        m_pipe[t]  = tap_pipe[t];
      end
      m_sd = int'(src_delay);
      first_seen = -1;
      dn = 0;
    end
    if (act && rn) begin
      if (cc >= m_sd) q.push_back(d);
      cc++;
    end else begin
      act = 0;
    end
  endtask

  // a run of ncyc cycles; samples count up from base after the source delay
  task automatic do_run(input string tag, input logic [DW-1:0] base, input int ncyc,
                        input int change_at);
    int sd;
    sd = int'(src_delay);
    for (int i = 0; i < ncyc; i++) begin
      if (i == change_at) begin
        tap_shift = ~tap_shift;
        tap_pipe  = ~tap_pipe;
        src_delay = src_delay + DLW'(5);
      end
      tick(i == 0, 1'b1, (i >= sd) ? base + DW'(i - sd) : DW'(16'hBAD0 + i), tag);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, DW'(16'h5A5A), tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 valid in reset", {15'd0, out_valid}, 16'd0);
    check("R1 sum in reset", sum_out, 16'd0);
    rst_n = 1'b1;
    idle(3, "R1 after reset");

    // R3 / R11: shifts 0..3, counter from 0
    tap_shift = {3'd3, 3'd2, 3'd1, 3'd0};
    tap_pipe  = 4'b0000;
    src_delay = '0;
    do_run("R3 R11 R7 stream", 16'd0, 14, -1);
    check("R3 first sum", dsum[0], 16'd6);
    check("R3 second sum", dsum[1], 16'd10);
    check("R3 third sum", dsum[2], 16'd14);
    check("R3 fourth sum", dsum[3], 16'd18);
    check("R6 latency plain", 16'(first_seen), 16'd4);

    // R8: running low clears valid
    idle(3, "R8 idle");

    // R2 R4 R5 R6: shuffled shifts, pipe on tap 1, source delay 3
    tap_shift = {3'd1, 3'd2, 3'd0, 3'd3};
    tap_pipe  = 4'b0010;
    src_delay = DLW'(3);
    do_run("R2 R4 R5 R6 skewed", 16'd100, 18, -1);
    check("R4 first sum with pipe", dsum[0], 16'd406);
    check("R6 latency with pipe", 16'(first_seen), 16'd8);

    // R4: same without pipe, one cycle earlier
    idle(2, "R8 idle");
    tap_pipe = 4'b0000;
    do_run("R4 no pipe", 16'd100, 14, -1);
    check("R4 same sum no pipe", dsum[0], 16'd406);
    check("R4 latency no pipe", 16'(first_seen), 16'd7);

    // R8: drop running mid-run, then a fresh run waits full latency again
    idle(1, "R8 drop");
    do_run("R8 rerun", 16'd7, 12, -1);
    check("R8 full latency again", 16'(first_seen), 16'd7);

    // R10: configuration changes inside a run are ignored
    tap_shift = {3'd2, 3'd0, 3'd1, 3'd4};
    tap_pipe  = 4'b0100;
    src_delay = DLW'(2);
    do_run("R10 change mid-run", 16'd40, 16, 5);

    // R12: restart while the previous run is producing sums
    tap_shift = {3'd0, 3'd1, 3'd2, 3'd3};
    tap_pipe  = 4'b0000;
    src_delay = DLW'(1);
    do_run("R12 restart", 16'd300, 6, -1);
    check("R12 restart latency", 16'(first_seen), 16'd5);
    idle(2, "R8 idle");

    // R9: wraparound
    tap_shift = {3'd4, 3'd5, 3'd6, 3'd7};
    tap_pipe  = 4'b0000;
    src_delay = DLW'(1);
    do_run("R9 wrap", 16'hFFF0, 16, -1);
    check("R9 wrapped sum", dsum[0], 16'hFFD6);
    idle(3, "R8 end");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule